// File: doc/BRIEF.md
# Serial Peripheral Low-Power Mode Controller

This block decides when an SPI-style serial peripheral may go quiet. It watches a stop request from the chip's power manager, a doze line from the same source, and two control-register bits: a software disable bit and a doze-enable bit. A frame-boundary strobe and a transfer-active flag come from the shift engine. Nothing changes mode in the middle of a serial frame. A stop or disable request that arrives while a frame is shifting is held pending until that frame ends. When no frame is active, the request takes effect at the next clock edge.

The block drives three kinds of output. The first is a stop acknowledge, which tells the power manager that the peripheral's clocks may now be removed. The second is a clock enable for the non-register logic, which goes low in both quiet modes. The last is a set of gating outputs. Interrupt and DMA request lines pass through a register that freezes while the block is stopped. Push and pop strobes for the transmit and receive FIFOs are turned into side-effect strobes that are suppressed whenever the clock enable was low. A register read or write then still completes on the bus, but it no longer moves a FIFO pointer. The shift engine, the FIFOs and the bus decoder are outside this block.

Top module: `spi_lowpower_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the block in the running state: clk_en_o = 1, stop_ack_o = 0, all irq_o, dma_o, push_fx_o and pop_fx_o bits 0.
- R2: While a stop request is pending during a frame (xfer_active_i = 1, frame_end_i = 0), stop_ack_o stays 0. It rises on the clock edge at which frame_end_i = 1.
- R3: With no transfer active (xfer_active_i = 0), stop_req_i = 1 makes stop_ack_o = 1 and clk_en_o = 0 right after the next clock edge.
- R4: Outside stop mode, irq_o and dma_o copy irq_i and dma_i one cycle later. While stop_ack_o = 1 they hold their values.
- R5: The disable condition is sw_disable_i OR (doze_i AND doze_en_i). doze_i with doze_en_i = 0 has no effect.
- R6: When the disable condition holds, clk_en_o falls at a frame boundary (frame_end_i = 1, or xfer_active_i = 0). It stays 1 while the current frame is still shifting.
- R7: A stop request takes priority over the disable condition, whether both arise together, the disable is pending, or the block is already disabled.
- R8: push_fx_o[k] and pop_fx_o[k] equal push_wr_i[k] and pop_rd_i[k] of the previous cycle ANDed with clk_en_o of that cycle. While the block is dormant, FIFO accesses have no side effect.
- R9: When stop_req_i drops, or the disable condition clears without a stop request, the next edge returns the block to running: clk_en_o = 1, stop_ack_o = 0.
- R10: stop_ack_o = 1 is never seen together with clk_en_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req_i | input | 1 | Stop request from the power manager |
| doze_i | input | 1 | Doze request from the power manager |
| sw_disable_i | input | 1 | Software disable bit from the control register |
| doze_en_i | input | 1 | Doze-enable bit from the control register |
| xfer_active_i | input | 1 | A serial frame is being shifted |
| frame_end_i | input | 1 | The current frame completes this cycle |
| irq_i | input | IRQ_W | Raw interrupt requests |
| dma_i | input | DMA_W | Raw DMA requests |
| push_wr_i | input | PUSH_W | Transmit-FIFO push register write strobes |
| pop_rd_i | input | POP_W | Receive-FIFO pop register read strobes |
| stop_ack_o | output | 1 | Clocks may be removed |
| clk_en_o | output | 1 | Clock enable for the non-register logic |
| irq_o | output | IRQ_W | Interrupt requests, frozen while stopped |
| dma_o | output | DMA_W | DMA requests, frozen while stopped |
| push_fx_o | output | PUSH_W | Push side-effect strobes to the transmit FIFO |
| pop_fx_o | output | POP_W | Pop side-effect strobes to the receive FIFO |

## Verification
The mode logic is walked through a cycle-by-cycle table of request combinations. Stop and disable requests are each applied with the shift engine idle and with a frame in flight. The in-flight cases tell an immediate entry apart from one deferred to the boundary. Doze is driven with and without its enable, which separates the AND term of the disable condition from the software bit. Overlapping stop and disable requests show that stop wins, from the running, pending and disabled states. Directed sequences then change the request lines during stop mode to show the freeze. They also issue FIFO strobes just before, during and just after disable, which pins the strobe gating to the clock enable of the strobe's own cycle.

// File: rtl/spi_lowpower_pkg.sv
package spi_lowpower_pkg;

   typedef enum logic [2:0] {
      LP_RUN          = 3'd0,
      LP_STOP_PEND    = 3'd1,
      LP_STOPPED      = 3'd2,
      LP_DIS_PEND     = 3'd3,
      LP_DISABLED     = 3'd4
   } lp_state_e;

   function automatic logic lp_dormant(input lp_state_e s);
      return (s == LP_STOPPED) || (s == LP_DISABLED);
   endfunction

endpackage

// File: rtl/spi_lowpower_cond.sv
module spi_lowpower_cond #(
   parameter int DOZE_SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic doze_i,
   input  logic doze_en_i,
   input  logic sw_disable_i,
   output logic dis_cond_o
);

   logic doze_s;

   generate
      if (DOZE_SYNC_STAGES < 0 || DOZE_SYNC_STAGES > 3) begin : g_bad_stages
         $error("DOZE_SYNC_STAGES must be within 0..3");
      end

      if (DOZE_SYNC_STAGES == 0) begin : g_direct
         assign doze_s = doze_i;
      end else begin : g_sync
         logic [DOZE_SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[DOZE_SYNC_STAGES-1:0], doze_i} >> 0;
         end
         assign doze_s = sync_q[DOZE_SYNC_STAGES-1];
      end
   endgenerate

   assign dis_cond_o = sw_disable_i | (doze_s & doze_en_i);

endmodule

// File: rtl/spi_lowpower_fsm.sv
module spi_lowpower_fsm
   import spi_lowpower_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic stop_req_i,
   input  logic dis_cond_i,
   input  logic xfer_active_i,
   input  logic frame_end_i,
   output logic stop_ack_o,
   output logic clk_en_o,
   output logic hold_nxt_o
);

   lp_state_e state_q, state_d;
   logic      boundary;

   assign boundary = !xfer_active_i || frame_end_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LP_RUN: begin
            if (stop_req_i)      state_d = boundary ? LP_STOPPED  : LP_STOP_PEND;
            else if (dis_cond_i) state_d = boundary ? LP_DISABLED : LP_DIS_PEND;
         end
         LP_STOP_PEND: begin
            if (!stop_req_i)     state_d = LP_RUN;
            else if (boundary)   state_d = LP_STOPPED;
         end
         LP_STOPPED: begin
            if (!stop_req_i)     state_d = LP_RUN;
         end
         LP_DIS_PEND: begin
            if (stop_req_i)      state_d = boundary ? LP_STOPPED : LP_STOP_PEND;
            else if (!dis_cond_i) state_d = LP_RUN;
            else if (boundary)   state_d = LP_DISABLED;
         end
         LP_DISABLED: begin
            if (stop_req_i)      state_d = boundary ? LP_STOPPED : LP_STOP_PEND;
            else if (!dis_cond_i) state_d = LP_RUN;
         end
         default:                state_d = LP_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= LP_RUN;
         stop_ack_o <= 1'b0;
         clk_en_o   <= 1'b1;
      end else begin
         state_q    <= state_d;
         stop_ack_o <= (state_d == LP_STOPPED);
         clk_en_o   <= !lp_dormant(state_d);
      end
   end

   assign hold_nxt_o = (state_d == LP_STOPPED);

endmodule

// File: rtl/spi_lowpower_freeze.sv
module spi_lowpower_freeze #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hold_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (W < 1) begin : g_bad_w
         $error("freeze width must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       q_o <= '0;
      else if (!hold_i) q_o <= d_i;
   end

endmodule

// File: rtl/spi_lowpower_gate.sv
module spi_lowpower_gate #(
   parameter int LANES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             live_i,
   input  logic [LANES-1:0] strobe_i,
   output logic [LANES-1:0] fx_o
);

   generate
      if (LANES < 1 || LANES > 16) begin : g_bad_lanes
         $error("strobe lane count must be within 1..16");
      end
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         always_ff @(posedge clk) begin
            if (!rst_n) fx_o[k] <= 1'b0;
            else        fx_o[k] <= strobe_i[k] & live_i;
         end
      end
   endgenerate

endmodule

// File: rtl/spi_lowpower_ctrl.sv
module spi_lowpower_ctrl #(
   parameter int IRQ_W            = 4,
   parameter int DMA_W            = 2,
   parameter int PUSH_W           = 1,
   parameter int POP_W            = 1,
   parameter int DOZE_SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop_req_i,
   input  logic              doze_i,
   input  logic              sw_disable_i,
   input  logic              doze_en_i,
   input  logic              xfer_active_i,
   input  logic              frame_end_i,
   input  logic [IRQ_W-1:0]  irq_i,
   input  logic [DMA_W-1:0]  dma_i,
   input  logic [PUSH_W-1:0] push_wr_i,
   input  logic [POP_W-1:0]  pop_rd_i,
   output logic              stop_ack_o,
   output logic              clk_en_o,
   output logic [IRQ_W-1:0]  irq_o,
   output logic [DMA_W-1:0]  dma_o,
   output logic [PUSH_W-1:0] push_fx_o,
   output logic [POP_W-1:0]  pop_fx_o
);

   localparam int REQ_W = IRQ_W + DMA_W;

   generate
      if (IRQ_W < 1 || DMA_W < 1) begin : g_bad_req
         $error("request widths must be at least 1");
      end
   endgenerate

   logic dis_cond;
   logic hold_nxt;
   logic [REQ_W-1:0] req_q;

   spi_lowpower_cond #(.DOZE_SYNC_STAGES(DOZE_SYNC_STAGES)) i_cond (
      .clk          (clk),
      .rst_n        (rst_n),
      .doze_i       (doze_i),
      .doze_en_i    (doze_en_i),
      .sw_disable_i (sw_disable_i),
      .dis_cond_o   (dis_cond)
   );

   spi_lowpower_fsm i_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .stop_req_i    (stop_req_i),
      .dis_cond_i    (dis_cond),
      .xfer_active_i (xfer_active_i),
      .frame_end_i   (frame_end_i),
      .stop_ack_o    (stop_ack_o),
      .clk_en_o      (clk_en_o),
      .hold_nxt_o    (hold_nxt)
   );

   spi_lowpower_freeze #(.W(REQ_W)) i_freeze (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (hold_nxt),
      .d_i    ({dma_i, irq_i}),
      .q_o    (req_q)
   );

   assign irq_o = req_q[IRQ_W-1:0];
   assign dma_o = req_q[REQ_W-1:IRQ_W];

   spi_lowpower_gate #(.LANES(PUSH_W)) i_push_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .live_i   (clk_en_o),
      .strobe_i (push_wr_i),
      .fx_o     (push_fx_o)
   );

   spi_lowpower_gate #(.LANES(POP_W)) i_pop_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .live_i   (clk_en_o),
      .strobe_i (pop_rd_i),
      .fx_o     (pop_fx_o)
   );

endmodule

// File: rtl/spi_lowpower_ctrl_chk.sv
module spi_lowpower_ctrl_chk #(
   parameter int IRQ_W  = 4,
   parameter int DMA_W  = 2,
   parameter int PUSH_W = 1,
   parameter int POP_W  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop_req_i,
   input logic              xfer_active_i,
   input logic              frame_end_i,
   input logic              stop_ack_o,
   input logic              clk_en_o,
   input logic [IRQ_W-1:0]  irq_o,
   input logic [DMA_W-1:0]  dma_o,
   input logic [PUSH_W-1:0] push_fx_o,
   input logic [POP_W-1:0]  pop_fx_o
);

   logic seen  = 1'b0;
   logic run_q = 1'b0;

   always_ff @(posedge clk) begin
      seen  <= 1'b1;
      run_q <= rst_n;
   end

   assert_reset_state_R1: assert property (@(posedge clk)
      (seen && !$past(rst_n)) |-> (clk_en_o && !stop_ack_o && push_fx_o == '0 && pop_fx_o == '0));

   assert_ack_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $rose(stop_ack_o)) |-> ($past(stop_req_i) && (!$past(xfer_active_i) || $past(frame_end_i))));

   assert_req_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && stop_ack_o) |-> ($stable(irq_o) && $stable(dma_o)));

   assert_clk_off_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && $fell(clk_en_o)) |-> (!$past(xfer_active_i) || $past(frame_end_i)));

   assert_fifo_fx_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !$past(clk_en_o)) |-> (push_fx_o == '0 && pop_fx_o == '0));

   assert_ack_excludes_clk_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ack_o |-> !clk_en_o);

endmodule

bind spi_lowpower_ctrl spi_lowpower_ctrl_chk #(
   .IRQ_W(IRQ_W), .DMA_W(DMA_W), .PUSH_W(PUSH_W), .POP_W(POP_W)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .stop_req_i    (stop_req_i),
   .xfer_active_i (xfer_active_i),
   .frame_end_i   (frame_end_i),
   .stop_ack_o    (stop_ack_o),
   .clk_en_o      (clk_en_o),
   .irq_o         (irq_o),
   .dma_o         (dma_o),
   .push_fx_o     (push_fx_o),
   .pop_fx_o      (pop_fx_o)
);

// File: tb/test_spi_lowpower_ctrl.sv
`timescale 1ns/1ps
module test_spi_lowpower_ctrl;

   localparam int IRQ_W = 4;
   localparam int DMA_W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stop_req = 0, doze = 0, sw_dis = 0, doze_en = 0, xfer = 0, fend = 0;
   logic [IRQ_W-1:0] irq = '0;
   logic [DMA_W-1:0] dma = '0;
   logic [0:0] push_wr = '0, pop_rd = '0;
   logic stop_ack, clk_en;
   logic [IRQ_W-1:0] irq_o;
   logic [DMA_W-1:0] dma_o;
   logic [0:0] push_fx, pop_fx;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   spi_lowpower_ctrl #(.IRQ_W(IRQ_W), .DMA_W(DMA_W)) i_spi_lowpower_ctrl (
      .clk(clk), .rst_n(rst_n), .stop_req_i(stop_req), .doze_i(doze),
      .sw_disable_i(sw_dis), .doze_en_i(doze_en), .xfer_active_i(xfer),
      .frame_end_i(fend), .irq_i(irq), .dma_i(dma), .push_wr_i(push_wr),
      .pop_rd_i(pop_rd), .stop_ack_o(stop_ack), .clk_en_o(clk_en),
      .irq_o(irq_o), .dma_o(dma_o), .push_fx_o(push_fx), .pop_fx_o(pop_fx)
   );

   // row bits: {stop, doze, sw_dis, doze_en, xfer, frame_end, exp_ack, exp_clk_en}
   localparam int NV = 20;
   localparam logic [7:0] VEC [NV] = '{
      8'b000000_01, // RUN idle (R1 follow-on)
      8'b100010_01, // stop in frame: pending (R2)
      8'b100010_01, // still pending (R2)
      8'b100011_10, // frame end: stopped (R2)
      8'b100000_10, // hold stopped
      8'b000000_01, // stop drop: run (R9)
      8'b010000_01, // doze without enable ignored (R5)
      8'b010110_01, // doze+enable in frame: pending (R5, R6)
      8'b010111_00, // boundary: disabled (R6)
      8'b000100_01, // doze clears: run (R9)
      8'b001000_00, // sw disable idle: immediate (R5, R6)
      8'b101000_10, // stop over disabled (R7, R3)
      8'b001000_01, // stop drops: run first (R9)
      8'b001000_00, // disable again
      8'b000000_01, // clears: run (R9)
      8'b101010_01, // both together in frame: stop pending (R7)
      8'b001010_01, // stop drops: run (R9)
      8'b001010_01, // disable pending (R6)
      8'b101011_10, // stop while disable pending at boundary (R7)
      8'b000000_01  // release (R9)
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic clear_in();
      stop_req = 0; doze = 0; sw_dis = 0; doze_en = 0; xfer = 0; fend = 0;
      push_wr = '0; pop_rd = '0;
   endtask

   initial begin : watchdog
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state
      rst_n = 0;
      tick(); tick();
      chk("R1 clk_en", clk_en, 1);
      chk("R1 stop_ack", stop_ack, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 fx", {push_fx, pop_fx}, 0);
      rst_n = 1;

      // table walk: R2 R3 R5 R6 R7 R9 R10
      for (int i = 0; i < NV; i++) begin
         {stop_req, doze, sw_dis, doze_en, xfer, fend} = VEC[i][7:2];
         tick();
         chk("R2/R3/R5/R6/R7/R9 ack", stop_ack, VEC[i][1]);
         chk("R5/R6/R7/R9 clk_en", clk_en, VEC[i][0]);
         chk("R10 exclusive", stop_ack & clk_en, 0);
      end
      clear_in(); tick();

      // R3: idle stop takes one edge
      stop_req = 1; tick();
      chk("R3 ack", stop_ack, 1);
      chk("R3 clk_en", clk_en, 0);
      stop_req = 0; tick();

      // R4: follow then freeze
      irq = 4'h5; dma = 2'b01; tick();
      chk("R4 irq follow", irq_o, 4'h5);
      chk("R4 dma follow", dma_o, 2'b01);
      stop_req = 1; irq = 4'hA; dma = 2'b10; tick();
      chk("R4 irq frozen on entry", irq_o, 4'h5);
      irq = 4'h3; dma = 2'b11; tick();
      chk("R4 irq frozen", irq_o, 4'h5);
      chk("R4 dma frozen", dma_o, 2'b01);
      stop_req = 0; tick();
      chk("R4 irq released", irq_o, 4'h3);
      chk("R4 dma released", dma_o, 2'b11);

      // R8: FIFO side-effect gating
      push_wr = 1; pop_rd = 1; tick();
      chk("R8 push live", push_fx, 1);
      chk("R8 pop live", pop_fx, 1);
      push_wr = 0; pop_rd = 0; sw_dis = 1; tick();
      chk("R8 idle", {push_fx, pop_fx}, 0);
      push_wr = 1; pop_rd = 1; tick();
      chk("R8 push blocked", push_fx, 0);
      chk("R8 pop blocked", pop_fx, 0);
      sw_dis = 0; tick();
      chk("R8 strobe in last dormant cycle blocked", {push_fx, pop_fx}, 0);
      tick();
      chk("R8 push live again", push_fx, 1);
      push_wr = 0; pop_rd = 0; tick();

      // R1: reset while stopped
      stop_req = 1; irq = 4'h9; tick();
      chk("R1 pre-reset ack", stop_ack, 1);
      rst_n = 0; tick();
      chk("R1 ack cleared", stop_ack, 0);
      chk("R1 clk_en set", clk_en, 1);
      chk("R1 irq cleared", irq_o, 0);
      rst_n = 1; clear_in(); tick();

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule